// File: doc/BRIEF.md
# Dual Audio Master Clock Divider

This block derives two audio master clocks from a single reference clock. A one-bit range input and a three-bit mode code choose a divisor of 1, 2, 3 or 4 for each output from a fixed two-output table. Divide-by-2 and divide-by-4 give square waves. Divide-by-3 gives a pulse that is high for one reference period out of three. Divide-by-1 passes the reference clock straight through. Range 1 is the usual setting with the fastest crystal; range 0 serves the two slower crystals.

Both outputs are timed from one shared frame counter that is twelve reference cycles long, the least common multiple of the divisors. A new selection is sampled and applied only on the reference edge that starts a frame. That edge ends a period for every divisor, so no high or low phase is ever cut short, and outputs that share a divisor stay phase-aligned. Range 0 with a mode code in the upper half of its range is reserved: the block keeps its previous selection and raises an error flag.

Top module: `audio_mclk_div`

## Requirements
- R1: While rst_n is low, mclk_a, mclk_b and sel_err are low. After release, both outputs run at divide-by-2 until the first selection is applied.
- R2: With range_sel 0, mode_sel 000/001/010/011 selects (mclk_a, mclk_b) divisors (1,2), (1,1), (2,2), (2,1).
- R3: With range_sel 1, mode code c (0..7) selects mclk_a divisor 2 + c/3 and mclk_b divisor 2 + (c mod 3), integer division.
- R4: Divide-by-2 and divide-by-4 outputs have a 50% duty cycle.
- R5: A divide-by-3 output is high for exactly one reference period of every three.
- R6: A divide-by-1 output equals ref_clk.
- R7: Counting reference rising edges from 1 after reset release, a divided output with divisor N (2, 3 or 4) is high after edge k exactly when (k mod N) < N/2 (integer division). Outputs with equal divisors are therefore phase-aligned.
- R8: range_sel and mode_sel are sampled only on edges where k is a multiple of 12; the new divisors take effect from that edge. Changes between those edges do not alter the running waveform.
- R9: Range 0 with mode_sel 100 to 111 is reserved. On a frame edge such a setting is ignored and the previous divisors stay. sel_err is high after every edge whose sampled inputs are reserved, and low after every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 1 | Crystal range select |
| mode_sel | input | 3 | Divisor pair code |
| mclk_a | output | 1 | First master clock |
| mclk_b | output | 1 | Second master clock |
| sel_err | output | 1 | Reserved setting seen on the last edge |

## Verification
Every code of both ranges is applied, and each output is sampled in both halves of twelve consecutive reference periods. Both halves are needed to tell a pass-through from a divided output, and the per-edge pattern tells divide-by-3 from a near-square wave. Pairs with equal divisors show alignment, and pairs with unequal divisors show that the two channels are independent. A change made mid-frame shows that the old pattern runs on until the frame edge. A reserved code shows that the selection is held while the error flag is raised.

// File: rtl/mclk_pkg.sv
`timescale 1ns/1ps
package mclk_pkg;
  // Divisor encoded as N-1: 0 -> /1, 1 -> /2, 2 -> /3, 3 -> /4
  typedef logic [1:0] div_t;

  typedef struct packed {
    div_t a;
    div_t b;
    logic ok;
  } sel_t;

  localparam div_t DIV_RESET = 2'd1;

  function automatic sel_t decode_sel(input logic rng, input logic [2:0] code);
    sel_t s;
    int unsigned c;
    c = int'(code);
    s.ok = 1'b1;
    s.a  = DIV_RESET;
    s.b  = DIV_RESET;
    if (rng) begin
      s.a = div_t'(1 + c / 3);
      s.b = div_t'(1 + c % 3);
    end else if (code[2]) begin
      s.ok = 1'b0;
    end else begin
      s.a = code[1] ? 2'd1 : 2'd0;
      s.b = code[0] ? 2'd0 : 2'd1;
    end
    return s;
  endfunction
endpackage

// File: rtl/mclk_frame_ctr.sv
`timescale 1ns/1ps
module mclk_frame_ctr #(
  parameter int FRAME = 12,
  localparam int W = $clog2(FRAME)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(FRAME - 1);
  logic [W-1:0] ph;

  assign wrap = (ph == LAST);
  assign nxt  = wrap ? '0 : ph + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= nxt;
  end
endmodule

// File: rtl/mclk_sel_decode.sv
`timescale 1ns/1ps
module mclk_sel_decode
  import mclk_pkg::*;
(
  input  logic       range_sel,
  input  logic [2:0] mode_sel,
  output div_t       div_a,
  output div_t       div_b,
  output logic       ok
);
  sel_t s;
  always_comb begin
    s     = decode_sel(range_sel, mode_sel);
    div_a = s.a;
    div_b = s.b;
    ok    = s.ok;
  end
endmodule

// File: rtl/mclk_chan.sv
`timescale 1ns/1ps
module mclk_chan
  import mclk_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt,
  input  logic         wrap,
  input  logic         load,
  input  div_t         div_new,
  output div_t         div_q,
  output logic         q,
  output logic         mclk
);
  div_t div_d;
  logic q_d;

  always_comb begin
    div_d = (wrap && load) ? div_new : div_q;
    unique case (div_d)
      2'd0:    q_d = 1'b0;
      2'd1:    q_d = ~nxt[0];
      2'd2:    q_d = ((int'(nxt) % 3) == 0);
      default: q_d = ~nxt[1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RESET;
      q     <= 1'b0;
    end else begin
      div_q <= div_d;
      q     <= q_d;
    end
  end

  assign mclk = (div_q == 2'd0) ? clk : q;

  p_apply_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> $past(wrap));
  p_third_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 2'd2 && q) |=> !q);
  p_half_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == 2'd1 && q) |=> !q);
endmodule

// File: rtl/audio_mclk_div.sv
`timescale 1ns/1ps
module audio_mclk_div
  import mclk_pkg::*;
#(
  parameter int FRAME = 12,  // must be a multiple of 12
  localparam int W = $clog2(FRAME),
  localparam int NCH = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       range_sel,
  input  logic [2:0] mode_sel,
  output logic       mclk_a,
  output logic       mclk_b,
  output logic       sel_err
);
  logic [W-1:0] nxt;
  logic         wrap;
  logic         ok;
  div_t         div_new [NCH];
  div_t         div_cur [NCH];
  logic         q       [NCH];
  logic         mclk    [NCH];

  mclk_frame_ctr #(.FRAME(FRAME)) u_frame (
    .clk(ref_clk), .rst_n(rst_n), .nxt(nxt), .wrap(wrap)
  );

  mclk_sel_decode u_dec (
    .range_sel(range_sel), .mode_sel(mode_sel),
    .div_a(div_new[0]), .div_b(div_new[1]), .ok(ok)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mclk_chan #(.W(W)) u_ch (
      .clk(ref_clk), .rst_n(rst_n), .nxt(nxt), .wrap(wrap), .load(ok),
      .div_new(div_new[i]), .div_q(div_cur[i]), .q(q[i]), .mclk(mclk[i])
    );
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sel_err <= 1'b0;
    else        sel_err <= ~ok;
  end

  assign mclk_a = mclk[0];
  assign mclk_b = mclk[1];

  p_err_holds_sel_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_err |-> ($stable(div_cur[0]) && $stable(div_cur[1])));
  p_same_div_aligned_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (div_cur[0] == div_cur[1] && div_cur[0] != 2'd0) |-> (q[0] == q[1]));
  p_low_in_reset_r1: assert property (@(posedge ref_clk)
    !rst_n |-> (!mclk_a && !mclk_b && !sel_err));
endmodule

// File: tb/audio_mclk_div_tb_top.sv
`timescale 1ns/1ps
module audio_mclk_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       range_sel = 1'b1;
  logic [2:0] mode_sel = 3'b101;
  logic       mclk_a, mclk_b, sel_err;
  int         k = 0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  audio_mclk_div dut_i (
    .ref_clk(clk), .rst_n(rst_n), .range_sel(range_sel), .mode_sel(mode_sel),
    .mclk_a(mclk_a), .mclk_b(mclk_b), .sel_err(sel_err)
  );

  always @(posedge clk) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  function automatic logic expv(int n, int kk, bit hi_half);
    if (n == 1) return hi_half;
    return ((kk % n) < (n / 2));
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Sample n cycles, each in both halves, starting at the next rising edge
  task automatic check_span(int na, int nb, int n, string req);
    int bad_a = 0, bad_b = 0;
    logic fa_act = 0, fa_exp = 0, fb_act = 0, fb_exp = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (mclk_a !== expv(na, k, 1'b1)) begin
        if (bad_a == 0) begin fa_act = mclk_a; fa_exp = expv(na, k, 1'b1); end
        bad_a++;
      end
      if (mclk_b !== expv(nb, k, 1'b1)) begin
        if (bad_b == 0) begin fb_act = mclk_b; fb_exp = expv(nb, k, 1'b1); end
        bad_b++;
      end
      @(negedge clk); #1;
      if (mclk_a !== expv(na, k, 1'b0)) begin
        if (bad_a == 0) begin fa_act = mclk_a; fa_exp = expv(na, k, 1'b0); end
        bad_a++;
      end
      if (mclk_b !== expv(nb, k, 1'b0)) begin
        if (bad_b == 0) begin fb_act = mclk_b; fb_exp = expv(nb, k, 1'b0); end
        bad_b++;
      end
    end
    checks += 2;
    if (bad_a != 0) begin
      errors++;
      $display("FAIL %s mclk_a /%0d: %0d bad samples, first actual=%b expected=%b",
               req, na, bad_a, fa_act, fa_exp);
    end
    if (bad_b != 0) begin
      errors++;
      $display("FAIL %s mclk_b /%0d: %0d bad samples, first actual=%b expected=%b",
               req, nb, bad_b, fb_act, fb_exp);
    end
  endtask

  // Wait until the next rising edge starts a frame, then check that frame
  task automatic check_frame(int na, int nb, string req);
    while (k % 12 != 11) begin @(posedge clk); #1; end
    check_span(na, nb, 12, req);
  endtask

  task automatic set_sel(logic r, logic [2:0] c);
    @(negedge clk);
    range_sel = r;
    mode_sel  = c;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", mclk_a, 1'b0, "mclk_a in reset (high half)");
    check("R1", mclk_b, 1'b0, "mclk_b in reset");
    check("R1", sel_err, 1'b0, "sel_err in reset");
    @(negedge clk); #1;
    check("R1", mclk_a, 1'b0, "mclk_a in reset (low half)");
    rst_n = 1'b1;
    check_span(2, 2, 11, "R1_R7 default /2 pair");
    check_span(3, 4, 12, "R3 code 101 first frame");
  endtask

  task automatic t_range0();
    set_sel(1'b0, 3'b000); check_frame(1, 2, "R2_R6 r0 code 000");
    set_sel(1'b0, 3'b001); check_frame(1, 1, "R2_R6 r0 code 001");
    set_sel(1'b0, 3'b010); check_frame(2, 2, "R2_R7 r0 code 010");
    set_sel(1'b0, 3'b011); check_frame(2, 1, "R2 r0 code 011");
  endtask

  task automatic t_range1();
    for (int c = 0; c < 8; c++) begin
      set_sel(1'b1, 3'(c));
      check_frame(2 + c / 3, 2 + c % 3, "R3_R4_R5_R7 r1 code");
    end
  endtask

  task automatic t_midframe();
    set_sel(1'b1, 3'b000);
    check_frame(2, 2, "R8 before change");
    while (k % 12 != 5) begin @(posedge clk); #1; end
    range_sel = 1'b1;
    mode_sel  = 3'b111;
    check_span(2, 2, 6, "R8 old pattern held to frame edge");
    check_span(4, 3, 12, "R8 new pattern from frame edge");
  endtask

  task automatic t_reserved();
    set_sel(1'b1, 3'b011);
    check_frame(3, 2, "R9 setup");
    set_sel(1'b0, 3'b110);
    @(posedge clk); #1;
    check("R9", sel_err, 1'b1, "sel_err after reserved code");
    check_frame(3, 2, "R9 selection held");
    check("R9", sel_err, 1'b1, "sel_err stays high");
    set_sel(1'b0, 3'b001);
    @(posedge clk); #1;
    check("R9", sel_err, 1'b0, "sel_err after valid code");
    check_frame(1, 1, "R9_R6 recovery");
  endtask

  initial begin
    t_reset();
    t_range0();
    t_range1();
    t_midframe();
    t_reserved();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule